// File: doc/BRIEF.md
# Descriptor Table Fetch Unit

This block turns a 16-bit segment selector into the 8-byte descriptor that the selector names. The descriptor comes from a table in memory. Software loads a table register with the table's 32-bit linear base address and a 16-bit size field. The size field holds the table length in bytes minus one, so a 65536-byte table (8192 descriptors) fits in it. A size of zero means the table holds no complete descriptor.

Each lookup starts with checks that need no memory access. A selector whose index is zero is refused as null. An index whose last byte lies past the size field is refused as out of range. A lookup that passes both checks reads the descriptor as two 32-bit words over a valid/ready request port; each read returns its data with a response strobe. If the present flag is clear, the lookup faults and nothing is written. If the accessed flag is clear, the unit writes the upper word back with that flag set. The result is returned as a 64-bit descriptor, a 2-bit status and a one-cycle done pulse. A busy flag stays high until the result is delivered, and the unit takes no new selector while it is high.

Top module: `desc_fetch_unit`

## Requirements
- R1: After reset the unit is idle, with busy, done and mem_req_valid all low. The table register resets to base 0 and size 0, so every lookup then faults.
- R2: A cycle with tbl_load high captures tbl_base_in and tbl_size_in. The next accepted lookup uses the new values for both address generation and range checking.
- R3: A selector with index bits [15:3] equal to zero completes with status 2 (null). No memory request is made, and selector bits [2:0] have no effect.
- R4: A lookup faults with status 1 (range) and makes no memory request when index*8+7 exceeds the size field. A lookup where index*8+7 equals the size field is in range.
- R5: An in-range lookup reads the lower word at base+index*8 and then the upper word at base+index*8+4. Only one request is outstanding at a time.
- R6: If bit 15 (present) of the upper word is 0, the lookup completes with status 3 (absent), an all-zero descriptor and no write.
- R7: If bit 8 (accessed) of the upper word is 0 on a present descriptor, exactly one write goes to base+index*8+4, carrying the upper word with bit 8 set. If the bit is already 1, no write is made.
- R8: A successful lookup gives status 0 and desc = {upper word with bit 8 set, lower word}. Every completion raises done for exactly one cycle. On any fault, desc is zero.
- R9: busy rises in the cycle after a request is accepted and stays high through the done cycle. A req_valid that arrives while busy is ignored.
- R10: While mem_req_valid is high and mem_req_ready is low, the request keeps its valid, address, write flag and write data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_load | input | 1 | Load the table register |
| tbl_base_in | input | 32 | Table linear base address to load |
| tbl_size_in | input | 16 | Table length in bytes minus one |
| req_valid | input | 1 | Selector lookup request, taken when busy is low |
| req_sel | input | 16 | Segment selector; bits 15:3 are the index |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle result strobe |
| status | output | 2 | 0 ok, 1 range fault, 2 null fault, 3 absent |
| desc | output | 64 | Fetched descriptor, zero on a fault |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Byte address of the 32-bit word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data |

## Verification
Lookups use selectors of four kinds. A fresh descriptor with the accessed flag clear exercises the write-back path. One with the flag already set shows that no write is made. One with the present flag clear separates the absent fault from success. Index zero, with and without low selector bits set, isolates the null check. The range check is driven one step inside and one step outside a table edge, and a zero-size table is tried as well. Read addresses are compared against two different base values, and the memory model throttles ready so that held requests and the ignored requests made while busy can both be seen.

// File: rtl/dfu_pkg.sv
// Shared types and field positions for the descriptor table fetch unit.
// Assumes an 8-byte descriptor fetched as two 32-bit words, lower word first.
package dfu_pkg;

    localparam int DESC_SHIFT   = 3;   // log2 of descriptor size in bytes
    localparam int PRESENT_BIT  = 15;  // position in the upper word
    localparam int ACCESSED_BIT = 8;   // position in the upper word
    localparam int HI_WORD_OFS  = 4;   // byte offset of the upper word

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_RANGE  = 2'd1,
        ST_NULL   = 2'd2,
        ST_ABSENT = 2'd3
    } dfu_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_LO,
        S_WT_LO,
        S_RD_HI,
        S_WT_HI,
        S_WR_ACC,
        S_DONE
    } dfu_state_e;

endpackage

// File: rtl/dfu_table_reg.sv
// Table register: holds the table base address and its size field
// (length in bytes minus one). Resets to an empty table (base 0, size 0).
module dfu_table_reg #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [SIZE_W-1:0] size_in,
    output logic [ADDR_W-1:0] base_q,
    output logic [SIZE_W-1:0] size_q
);

    // Capture base and size when software loads the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
        end else if (load) begin
            base_q <= base_in;
            size_q <= size_in;
        end
    end

endmodule

// File: rtl/dfu_bound_check.sv
// Selector decode: extracts the index, flags the null selector and an index
// whose last byte lies past the size field, and forms the entry byte address.
// Purely combinational; low selector bits below the index are not used.
module dfu_bound_check #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16,
    parameter int SEL_W  = 16
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] base,
    output logic              is_null,
    output logic              out_of_range,
    output logic [ADDR_W-1:0] entry_addr
);
    import dfu_pkg::*;

    localparam int IDX_W = SEL_W - DESC_SHIFT;
    localparam int OFF_W = SEL_W + 1;
    localparam int CMP_W = (OFF_W > SIZE_W) ? OFF_W : SIZE_W;

    logic [IDX_W-1:0] index;
    logic [CMP_W-1:0] last_byte;
    logic [CMP_W-1:0] size_ext;
    logic             sel_low_unused;

    // Split the selector and compare the entry's last byte to the size field.
    always_comb begin
        index          = sel[SEL_W-1:DESC_SHIFT];
        sel_low_unused = ^sel[DESC_SHIFT-1:0];
        last_byte      = CMP_W'({index, {DESC_SHIFT{1'b1}}});
        size_ext       = CMP_W'(size);
        is_null        = (index == '0);
        out_of_range   = (last_byte > size_ext);
        entry_addr     = base + ADDR_W'({index, {DESC_SHIFT{1'b0}}});
    end

endmodule

// File: rtl/dfu_fetch_fsm.sv
// Lookup sequencer: accepts a checked selector, reads the two descriptor
// words, tests the present flag, writes the accessed flag back when clear,
// and reports the result with a one-cycle done strobe. One request at a time.
module dfu_fetch_fsm #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                is_null,
    input  logic                out_of_range,
    input  logic [ADDR_W-1:0]   entry_addr,
    output logic                busy,
    output logic                done,
    output logic [1:0]          status,
    output logic [2*WORD_W-1:0] desc,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic                mem_req_we,
    output logic [ADDR_W-1:0]   mem_req_addr,
    output logic [WORD_W-1:0]   mem_req_wdata,
    input  logic                mem_rsp_valid,
    input  logic [WORD_W-1:0]   mem_rsp_data
);
    import dfu_pkg::*;

    dfu_state_e        state_q;
    dfu_status_e       status_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] lo_q;
    logic [WORD_W-1:0] hi_q;

    // Step through checks, reads and write-back; latch words and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            status_q <= ST_OK;
            addr_q   <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (req_valid) begin
                    addr_q <= entry_addr;
                    lo_q   <= '0;
                    hi_q   <= '0;
                    if (is_null) begin
                        status_q <= ST_NULL;
                        state_q  <= S_DONE;
                    end else if (out_of_range) begin
                        status_q <= ST_RANGE;
                        state_q  <= S_DONE;
                    end else begin
                        status_q <= ST_OK;
                        state_q  <= S_RD_LO;
                    end
                end
                S_RD_LO: if (mem_req_ready) state_q <= S_WT_LO;
                S_WT_LO: if (mem_rsp_valid) begin
                    lo_q    <= mem_rsp_data;
                    state_q <= S_RD_HI;
                end
                S_RD_HI: if (mem_req_ready) state_q <= S_WT_HI;
                S_WT_HI: if (mem_rsp_valid) begin
                    if (!mem_rsp_data[PRESENT_BIT]) begin
                        status_q <= ST_ABSENT;
                        lo_q     <= '0;
                        state_q  <= S_DONE;
                    end else begin
                        hi_q                <= mem_rsp_data;
                        hi_q[ACCESSED_BIT]  <= 1'b1;
                        state_q <= mem_rsp_data[ACCESSED_BIT] ? S_DONE : S_WR_ACC;
                    end
                end
                S_WR_ACC: if (mem_req_ready) state_q <= S_DONE;
                default:  state_q <= S_IDLE;
            endcase
        end
    end

    // Drive the memory request and the result outputs from the current state.
    always_comb begin
        busy          = (state_q != S_IDLE);
        done          = (state_q == S_DONE);
        status        = status_q;
        desc          = (status_q == ST_OK) ? {hi_q, lo_q} : '0;
        mem_req_valid = (state_q == S_RD_LO) || (state_q == S_RD_HI) ||
                        (state_q == S_WR_ACC);
        mem_req_we    = (state_q == S_WR_ACC);
        mem_req_addr  = (state_q == S_RD_LO) ? addr_q
                                             : addr_q + ADDR_W'(HI_WORD_OFS);
        mem_req_wdata = hi_q;
    end

endmodule

// File: rtl/desc_fetch_unit.sv
// Descriptor table fetch unit top: table register, selector check and
// lookup sequencer. Assumes a memory that accepts one 32-bit request per
// valid/ready handshake and returns read data later with a strobe.
module desc_fetch_unit #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16,
    parameter int SEL_W  = 16,
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tbl_load,
    input  logic [ADDR_W-1:0]   tbl_base_in,
    input  logic [SIZE_W-1:0]   tbl_size_in,
    input  logic                req_valid,
    input  logic [SEL_W-1:0]    req_sel,
    output logic                busy,
    output logic                done,
    output logic [1:0]          status,
    output logic [2*WORD_W-1:0] desc,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic                mem_req_we,
    output logic [ADDR_W-1:0]   mem_req_addr,
    output logic [WORD_W-1:0]   mem_req_wdata,
    input  logic                mem_rsp_valid,
    input  logic [WORD_W-1:0]   mem_rsp_data
);

    logic [ADDR_W-1:0] tbl_base;
    logic [SIZE_W-1:0] tbl_size;
    logic              sel_null;
    logic              sel_oor;
    logic [ADDR_W-1:0] sel_addr;

    dfu_table_reg #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_table (
        .clk(clk), .rst_n(rst_n), .load(tbl_load),
        .base_in(tbl_base_in), .size_in(tbl_size_in),
        .base_q(tbl_base), .size_q(tbl_size)
    );

    dfu_bound_check #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SEL_W(SEL_W)) i_check (
        .sel(req_sel), .size(tbl_size), .base(tbl_base),
        .is_null(sel_null), .out_of_range(sel_oor), .entry_addr(sel_addr)
    );

    dfu_fetch_fsm #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .is_null(sel_null), .out_of_range(sel_oor), .entry_addr(sel_addr),
        .busy(busy), .done(done), .status(status), .desc(desc),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

endmodule

// File: rtl/dfu_checker.sv
// Port-level properties of the descriptor table fetch unit, bound to the top.
module dfu_checker #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                busy,
    input logic                done,
    input logic [1:0]          status,
    input logic [2*WORD_W-1:0] desc,
    input logic                mem_req_valid,
    input logic                mem_req_ready,
    input logic                mem_req_we,
    input logic [ADDR_W-1:0]   mem_req_addr,
    input logic [WORD_W-1:0]   mem_req_wdata
);

    assert_mem_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    assert_idle_accepts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_ok_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd0) |-> (desc[WORD_W+15] && desc[WORD_W+8]));

    assert_wb_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> (mem_req_wdata[15] && mem_req_wdata[8]));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) &&
             $stable(mem_req_wdata)));

endmodule

bind desc_fetch_unit dfu_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_dfu_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
    .status(status), .desc(desc), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata)
);

// File: tb/test_desc_fetch_unit.sv
// Directed bench: one task per scenario, each checking its own results.
module test_desc_fetch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_load = 1'b0;
    logic [31:0] tbl_base_in = '0;
    logic [15:0] tbl_size_in = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_sel = '0;
    logic        busy, done, mem_req_valid, mem_req_we;
    logic [1:0]  status;
    logic [63:0] desc;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_req_ready;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    desc_fetch_unit i_desc_fetch_unit (
        .clk(clk), .rst_n(rst_n), .tbl_load(tbl_load),
        .tbl_base_in(tbl_base_in), .tbl_size_in(tbl_size_in),
        .req_valid(req_valid), .req_sel(req_sel), .busy(busy), .done(done),
        .status(status), .desc(desc), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // Memory model: 64 words, throttled ready, one-cycle read response.
    logic [31:0] mem [64];
    logic        poke_en = 1'b0;
    logic [5:0]  poke_idx = '0;
    logic [31:0] poke_data = '0;
    logic        cnt_clr = 1'b0;
    int          tick = 0, rd_cnt = 0, wr_cnt = 0, done_cnt = 0, hold_viol = 0;
    logic [31:0] rd_addr0 = '0, rd_addr1 = '0, wr_addr = '0, wr_data = '0;
    logic        pend_q = 1'b0;
    logic [31:0] pend_addr = '0;

    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
    end

    always @(posedge clk) begin
        tick          <= tick + 1;
        mem_req_ready <= (tick % 3) != 0;
        mem_rsp_valid <= 1'b0;
        if (poke_en) mem[poke_idx] <= poke_data;
        if (cnt_clr) begin
            rd_cnt <= 0; wr_cnt <= 0; done_cnt <= 0;
        end else begin
            if (done) done_cnt <= done_cnt + 1;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_we) begin
                    mem[mem_req_addr[7:2]] <= mem_req_wdata;
                    wr_cnt  <= wr_cnt + 1;
                    wr_addr <= mem_req_addr;
                    wr_data <= mem_req_wdata;
                end else begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= mem[mem_req_addr[7:2]];
                    if (rd_cnt == 0) rd_addr0 <= mem_req_addr;
                    if (rd_cnt == 1) rd_addr1 <= mem_req_addr;
                    rd_cnt <= rd_cnt + 1;
                end
            end
        end
        if (rst_n && pend_q && (!mem_req_valid || mem_req_addr != pend_addr))
            hold_viol <= hold_viol + 1;
        pend_q    <= rst_n && mem_req_valid && !mem_req_ready;
        pend_addr <= mem_req_addr;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input int idx, input logic [31:0] data);
        @(negedge clk);
        poke_en = 1'b1; poke_idx = 6'(idx); poke_data = data;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic load_table(input logic [31:0] base, input logic [15:0] size);
        @(negedge clk);
        tbl_load = 1'b1; tbl_base_in = base; tbl_size_in = size;
        @(negedge clk);
        tbl_load = 1'b0;
    endtask

    // Issue one lookup; optionally keep req_valid high for extra cycles.
    task automatic lookup(input logic [15:0] sel, input int hold,
                          input logic [15:0] other_sel,
                          output logic [1:0] st, output logic [63:0] d);
        @(negedge clk);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        req_valid = 1'b1; req_sel = sel;
        @(negedge clk);
        check(busy == 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
        req_sel = other_sel;
        for (int i = 0; i < hold; i++) @(negedge clk);
        req_valid = 1'b0;
        st = 2'bxx; d = 'x;
        for (int i = 0; i < 60; i++) begin
            if (done) begin
                st = status; d = desc;
                break;
            end
            @(negedge clk);
        end
        check(st !== 2'bxx, "R8 done seen", 64'(st), 64'd0);
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R9 idle after done", 64'(busy), 64'd0);
    endtask

    task automatic t_reset();
        logic [1:0] st; logic [63:0] d;
        check(!busy && !done && !mem_req_valid, "R1 reset outputs",
              64'({busy, done, mem_req_valid}), 64'd0);
        lookup(16'h0008, 0, 16'h0, st, d);
        check(st == 2'd1, "R1 empty table faults", 64'(st), 64'd1);
        check(rd_cnt == 0, "R4 no read on range fault", 64'(rd_cnt), 64'd0);
    endtask

    task automatic t_null();
        logic [1:0] st; logic [63:0] d;
        lookup(16'h0000, 0, 16'h0, st, d);
        check(st == 2'd2, "R3 null status", 64'(st), 64'd2);
        check(rd_cnt == 0 && wr_cnt == 0, "R3 no memory access", 64'(rd_cnt + wr_cnt), 64'd0);
        lookup(16'h0007, 0, 16'h0, st, d);
        check(st == 2'd2, "R3 low bits ignored", 64'(st), 64'd2);
        check(d == 64'd0, "R8 zero desc on fault", d, 64'd0);
    endtask

    task automatic t_fresh();
        logic [1:0] st; logic [63:0] d;
        lookup(16'h000B, 0, 16'h0, st, d);
        check(st == 2'd0, "R8 ok status", 64'(st), 64'd0);
        check(d == 64'h00CF9B00_11112222, "R8 descriptor", d, 64'h00CF9B00_11112222);
        check(rd_cnt == 2, "R5 two reads", 64'(rd_cnt), 64'd2);
        check(rd_addr0 == 32'h48, "R5 lower word address", 64'(rd_addr0), 64'h48);
        check(rd_addr1 == 32'h4C, "R5 upper word address", 64'(rd_addr1), 64'h4C);
        check(wr_cnt == 1, "R7 one write-back", 64'(wr_cnt), 64'd1);
        check(wr_addr == 32'h4C && wr_data == 32'h00CF9B00, "R7 write-back word",
              {wr_addr, wr_data}, {32'h4C, 32'h00CF9B00});
        check(mem[19] == 32'h00CF9B00, "R7 memory updated", 64'(mem[19]), 64'h00CF9B00);
    endtask

    task automatic t_accessed();
        logic [1:0] st; logic [63:0] d;
        lookup(16'h0010, 0, 16'h0, st, d);
        check(st == 2'd0, "R8 ok status accessed", 64'(st), 64'd0);
        check(d == 64'h00CF9300_33334444, "R8 descriptor accessed", d, 64'h00CF9300_33334444);
        check(wr_cnt == 0, "R7 no write when set", 64'(wr_cnt), 64'd0);
    endtask

    task automatic t_absent();
        logic [1:0] st; logic [63:0] d;
        lookup(16'h0018, 0, 16'h0, st, d);
        check(st == 2'd3, "R6 absent status", 64'(st), 64'd3);
        check(d == 64'd0, "R6 zero descriptor", d, 64'd0);
        check(wr_cnt == 0 && rd_cnt == 2, "R6 reads only",
              64'({rd_cnt[7:0], wr_cnt[7:0]}), 64'h0200);
    endtask

    task automatic t_bounds();
        logic [1:0] st; logic [63:0] d;
        lookup(16'h0020, 0, 16'h0, st, d);
        check(st == 2'd1, "R4 index past table", 64'(st), 64'd1);
        load_table(32'h40, 16'd39);
        lookup(16'h0020, 0, 16'h0, st, d);
        check(st == 2'd0, "R4 last byte equals size", 64'(st), 64'd0);
        check(d == 64'h00409300_55556666, "R2 new size used", d, 64'h00409300_55556666);
        load_table(32'h40, 16'd38);
        lookup(16'h0020, 0, 16'h0, st, d);
        check(st == 2'd1, "R4 one byte short", 64'(st), 64'd1);
        check(rd_cnt == 0, "R4 no read", 64'(rd_cnt), 64'd0);
    endtask

    task automatic t_busy();
        logic [1:0] st; logic [63:0] d;
        lookup(16'h0010, 2, 16'h0008, st, d);
        check(done_cnt == 1, "R9 one completion while busy", 64'(done_cnt), 64'd1);
        check(rd_cnt == 2 && rd_addr0 == 32'h50, "R9 request while busy ignored",
              64'({rd_cnt[7:0], rd_addr0}), 64'h02_00000050);
    endtask

    task automatic t_rebase();
        logic [1:0] st; logic [63:0] d;
        load_table(32'h80, 16'd15);
        lookup(16'h0008, 0, 16'h0, st, d);
        check(rd_addr0 == 32'h88 && rd_addr1 == 32'h8C, "R2 new base used",
              {rd_addr0, rd_addr1}, {32'h88, 32'h8C});
        check(d == 64'h00CF9300_77778888, "R5 rebased descriptor", d, 64'h00CF9300_77778888);
        check(hold_viol == 0, "R10 held requests stable", 64'(hold_viol), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        poke(18, 32'h11112222); poke(19, 32'h00CF9A00);
        poke(20, 32'h33334444); poke(21, 32'h00CF9300);
        poke(22, 32'hAAAABBBB); poke(23, 32'h00CF1A00);
        poke(24, 32'h55556666); poke(25, 32'h00409300);
        poke(34, 32'h77778888); poke(35, 32'h00CF9300);
        t_reset();
        load_table(32'h40, 16'd31);
        t_null();
        t_fresh();
        t_accessed();
        t_absent();
        t_busy();
        t_bounds();
        t_rebase();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule